// File: doc/BRIEF.md
# Dual-Issue Pairing and Issue Stage

This block is the in-order issue stage of a partial dual-issue pipeline. In each cycle it looks at the two oldest decoded instructions. It then issues both of them, only the older one, or nothing.

Each instruction arrives as a descriptor with these fields:
- a class
- a destination register
- up to two source registers
- an enable flag for each register field

The block decides whether the pair may go out together from four things:
- an ordered class-pair compatibility matrix
- the three register-file read ports
- same-cycle data dependences between the two slots
- a per-register scoreboard of results still in flight in the multi-cycle units

When a pair issues, the block steers each instruction to a pipe. Shift and multiply work always goes to the one ALU that has the barrel shifter and the multiplier. The block also reports how many instructions the front end may retire from its queue.

Class codes are mov=0, register ALU=1, ALU-with-immediate=2, multiply=3, shift=4, branch=5, load/store=6, nop=7. Pipe codes are simple ALU=0, complex ALU=1, load/store pipe=2, branch pipe=3.

Top module: `dual_issue_stage`

## Requirements
- R1: After reset no register is pending. A valid slot-0 instruction issues in the first cycle after reset is released.
- R2: When slot-0 valid is low, nothing issues (count 0). When slot-1 valid is low, at most slot 0 issues (count 0 or 1).
- R3: If the younger instruction reads an enabled source equal to the older instruction's enabled destination, the pair is split and only slot 0 issues. A source whose enable flag is low causes no split.
- R4: The pair is split when the two instructions together need more than RD_PORTS (3) register reads. The number of reads is the count of enabled source fields. This holds even for class pairs the matrix allows, such as load/store with a two-source ALU-with-immediate.
- R5: Pairing follows this ordered matrix, written as older -> younger classes that may pair:
  - mov -> mov, ALU, ALU-imm, shift, branch
  - ALU -> mov, ALU-imm, branch
  - ALU-imm -> mov, ALU, ALU-imm, shift, branch, load/store
  - multiply -> branch
  - shift -> ALU-imm, branch
  - branch -> every class except branch and nop
  - load/store -> mov, ALU-imm, branch
  - nop -> nothing
- R6: A nop never issues together with another instruction, in either slot.
- R7: issue_cnt_o is 2 when both slots issue, 1 when only slot 0 issues, and 0 otherwise. Slot 1 never issues without slot 0.
- R8: Multiply and shift go to the complex ALU (1), load/store to pipe 2, branch to pipe 3, nop to pipe 0. For mov, ALU and ALU-imm: in slot 0 they go to the complex ALU unless the paired slot 1 needs it, in which case they go to the simple ALU. In slot 1 they always go to the simple ALU. A dual-issued pair never shares a pipe.
- R9: A multiply or load/store that issues with its destination enabled marks that register pending for MULTI_LAT-1 cycles (2 with defaults). The first cycle in which a dependent instruction may issue is MULTI_LAT cycles after the producer issued.
- R10: An instruction whose enabled source or destination is pending is held. A held slot 0 also holds slot 1, so nothing issues.
- R11: Independent multiplies or load/stores issue back to back, one per cycle, with no stall.
- R12: Two instructions whose enabled destinations are the same register do not pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| s0_valid_i | input | 1 | Older slot holds an instruction |
| s0_cls_i | input | 3 | Older instruction class |
| s0_rd_i | input | REG_AW (4) | Older destination register |
| s0_rd_en_i | input | 1 | Older instruction writes a register |
| s0_rs1_i | input | REG_AW (4) | Older first source |
| s0_rs1_en_i | input | 1 | Older first source is read |
| s0_rs2_i | input | REG_AW (4) | Older second source |
| s0_rs2_en_i | input | 1 | Older second source is read |
| s1_valid_i | input | 1 | Younger slot holds an instruction |
| s1_cls_i | input | 3 | Younger instruction class |
| s1_rd_i | input | REG_AW (4) | Younger destination register |
| s1_rd_en_i | input | 1 | Younger instruction writes a register |
| s1_rs1_i | input | REG_AW (4) | Younger first source |
| s1_rs1_en_i | input | 1 | Younger first source is read |
| s1_rs2_i | input | REG_AW (4) | Younger second source |
| s1_rs2_en_i | input | 1 | Younger second source is read |
| issue0_o | output | 1 | Slot 0 issues this cycle |
| issue1_o | output | 1 | Slot 1 issues this cycle |
| pipe0_o | output | 2 | Pipe chosen for slot 0 |
| pipe1_o | output | 2 | Pipe chosen for slot 1 |
| issue_cnt_o | output | 2 | Instructions consumed (0, 1 or 2) |

## Verification
The assertions check the pairing invariants on every cycle:
- slot 1 never issues alone
- no same-cycle read-after-write pair issues
- no nop pairs
- the read-port budget is never exceeded
- dual-issued instructions never share a pipe
- shift and multiply always land on the complex ALU
- a consumer is held in the cycle right after its multi-cycle producer issues

Other behaviours only the bench scenarios can show. These are the exact shape of the compatibility matrix for each class pair, the steering of the non-complex slot, and the release cycle of a held dependent. The same applies to in-order blocking of an independent younger instruction and to back-to-back throughput of independent multiplies and loads.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;

  typedef enum logic [2:0] {
    CLS_MOV  = 3'd0,
    CLS_ALU  = 3'd1,
    CLS_ALUI = 3'd2,
    CLS_MUL  = 3'd3,
    CLS_SHF  = 3'd4,
    CLS_BR   = 3'd5,
    CLS_LDST = 3'd6,
    CLS_NOP  = 3'd7
  } insn_cls_e;

  typedef enum logic [1:0] {
    PIPE_SIMPLE  = 2'd0,
    PIPE_COMPLEX = 2'd1,
    PIPE_LSU     = 2'd2,
    PIPE_BR      = 2'd3
  } pipe_e;

  // ordered compatibility: older class first
  function automatic logic cls_pair_ok(insn_cls_e older, insn_cls_e younger);
    logic ok;
    ok = 1'b0;
    case (older)
      CLS_MOV:  ok = younger inside {CLS_MOV, CLS_ALU, CLS_ALUI, CLS_SHF, CLS_BR};
      CLS_ALU:  ok = younger inside {CLS_MOV, CLS_ALUI, CLS_BR};
      CLS_ALUI: ok = younger inside {CLS_MOV, CLS_ALU, CLS_ALUI, CLS_SHF, CLS_BR, CLS_LDST};
      CLS_MUL:  ok = (younger == CLS_BR);
      CLS_SHF:  ok = younger inside {CLS_ALUI, CLS_BR};
      CLS_BR:   ok = younger inside {CLS_MOV, CLS_ALU, CLS_ALUI, CLS_MUL, CLS_SHF, CLS_LDST};
      CLS_LDST: ok = younger inside {CLS_MOV, CLS_ALUI, CLS_BR};
      default:  ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic needs_complex(insn_cls_e c);
    return (c == CLS_MUL) || (c == CLS_SHF);
  endfunction

  function automatic logic is_multi_cycle(insn_cls_e c);
    return (c == CLS_MUL) || (c == CLS_LDST);
  endfunction

endpackage

// File: rtl/di_pair_check.sv
module di_pair_check
  import dual_issue_pkg::*;
#(
  parameter int REG_AW   = 4,
  parameter int RD_PORTS = 3
) (
  input  insn_cls_e          cls0_i,
  input  insn_cls_e          cls1_i,
  input  logic [REG_AW-1:0]  rd0_i,
  input  logic               rd0_en_i,
  input  logic               rs1_0_en_i,
  input  logic               rs2_0_en_i,
  input  logic [REG_AW-1:0]  rd1_i,
  input  logic               rd1_en_i,
  input  logic [REG_AW-1:0]  rs1_1_i,
  input  logic               rs1_1_en_i,
  input  logic [REG_AW-1:0]  rs2_1_i,
  input  logic               rs2_1_en_i,
  output logic               pair_ok_o
);

  localparam int CntW = $clog2(RD_PORTS + 2) + 1;

  logic            raw_hit;
  logic            waw_hit;
  logic [CntW-1:0] reads;

  assign raw_hit = rd0_en_i && ((rs1_1_en_i && (rs1_1_i == rd0_i)) ||
                                (rs2_1_en_i && (rs2_1_i == rd0_i)));
  assign waw_hit = rd0_en_i && rd1_en_i && (rd0_i == rd1_i);
  assign reads   = CntW'(rs1_0_en_i) + CntW'(rs2_0_en_i) +
                   CntW'(rs1_1_en_i) + CntW'(rs2_1_en_i);

  assign pair_ok_o = cls_pair_ok(cls0_i, cls1_i) && !raw_hit && !waw_hit &&
                     (reads <= CntW'(RD_PORTS));

endmodule

// File: rtl/di_scoreboard.sv
module di_scoreboard #(
  parameter int NUM_REGS  = 16,
  parameter int MULTI_LAT = 3,
  parameter int REG_AW    = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] q0_rs1_i,
  input  logic              q0_rs1_en_i,
  input  logic [REG_AW-1:0] q0_rs2_i,
  input  logic              q0_rs2_en_i,
  input  logic [REG_AW-1:0] q0_rd_i,
  input  logic              q0_rd_en_i,
  input  logic [REG_AW-1:0] q1_rs1_i,
  input  logic              q1_rs1_en_i,
  input  logic [REG_AW-1:0] q1_rs2_i,
  input  logic              q1_rs2_en_i,
  input  logic [REG_AW-1:0] q1_rd_i,
  input  logic              q1_rd_en_i,
  input  logic              set0_i,
  input  logic [REG_AW-1:0] set0_rd_i,
  input  logic              set1_i,
  input  logic [REG_AW-1:0] set1_rd_i,
  output logic              block0_o,
  output logic              block1_o
);

  localparam int CW = (MULTI_LAT > 2) ? $clog2(MULTI_LAT) : 1;

  logic [CW-1:0]       cnt_q [NUM_REGS];
  logic [NUM_REGS-1:0] pend;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic load;
    assign load = (set0_i && (set0_rd_i == REG_AW'(r))) ||
                  (set1_i && (set1_rd_i == REG_AW'(r)));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q[r] <= '0;
      else if (load)            cnt_q[r] <= CW'(MULTI_LAT - 1);
      else if (cnt_q[r] != '0)  cnt_q[r] <= cnt_q[r] - 1'b1;
    end
    assign pend[r] = (cnt_q[r] != '0);
  end

  assign block0_o = (q0_rs1_en_i && pend[q0_rs1_i]) ||
                    (q0_rs2_en_i && pend[q0_rs2_i]) ||
                    (q0_rd_en_i  && pend[q0_rd_i]);
  assign block1_o = (q1_rs1_en_i && pend[q1_rs1_i]) ||
                    (q1_rs2_en_i && pend[q1_rs2_i]) ||
                    (q1_rd_en_i  && pend[q1_rd_i]);

endmodule

// File: rtl/di_steer.sv
module di_steer
  import dual_issue_pkg::*;
(
  input  insn_cls_e cls0_i,
  input  insn_cls_e cls1_i,
  input  logic      dual_i,
  output pipe_e     pipe0_o,
  output pipe_e     pipe1_o
);

  always_comb begin
    case (cls0_i)
      CLS_MUL, CLS_SHF: pipe0_o = PIPE_COMPLEX;
      CLS_LDST:         pipe0_o = PIPE_LSU;
      CLS_BR:           pipe0_o = PIPE_BR;
      CLS_NOP:          pipe0_o = PIPE_SIMPLE;
      default:          pipe0_o = (dual_i && needs_complex(cls1_i)) ? PIPE_SIMPLE
                                                                    : PIPE_COMPLEX;
    endcase
    case (cls1_i)
      CLS_MUL, CLS_SHF: pipe1_o = PIPE_COMPLEX;
      CLS_LDST:         pipe1_o = PIPE_LSU;
      CLS_BR:           pipe1_o = PIPE_BR;
      default:          pipe1_o = PIPE_SIMPLE;
    endcase
  end

endmodule

// File: rtl/dual_issue_stage.sv
module dual_issue_stage
  import dual_issue_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int MULTI_LAT = 3,
  parameter int RD_PORTS  = 3,
  localparam int REG_AW   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              s0_valid_i,
  input  logic [2:0]        s0_cls_i,
  input  logic [REG_AW-1:0] s0_rd_i,
  input  logic              s0_rd_en_i,
  input  logic [REG_AW-1:0] s0_rs1_i,
  input  logic              s0_rs1_en_i,
  input  logic [REG_AW-1:0] s0_rs2_i,
  input  logic              s0_rs2_en_i,
  input  logic              s1_valid_i,
  input  logic [2:0]        s1_cls_i,
  input  logic [REG_AW-1:0] s1_rd_i,
  input  logic              s1_rd_en_i,
  input  logic [REG_AW-1:0] s1_rs1_i,
  input  logic              s1_rs1_en_i,
  input  logic [REG_AW-1:0] s1_rs2_i,
  input  logic              s1_rs2_en_i,
  output logic              issue0_o,
  output logic              issue1_o,
  output logic [1:0]        pipe0_o,
  output logic [1:0]        pipe1_o,
  output logic [1:0]        issue_cnt_o
);

  insn_cls_e cls0, cls1;
  logic      pair_ok, block0, block1, set0, set1;
  pipe_e     pipe0, pipe1;

  assign cls0 = insn_cls_e'(s0_cls_i);
  assign cls1 = insn_cls_e'(s1_cls_i);

  di_pair_check #(.REG_AW(REG_AW), .RD_PORTS(RD_PORTS)) u_pair (
    .cls0_i(cls0), .cls1_i(cls1),
    .rd0_i(s0_rd_i), .rd0_en_i(s0_rd_en_i),
    .rs1_0_en_i(s0_rs1_en_i), .rs2_0_en_i(s0_rs2_en_i),
    .rd1_i(s1_rd_i), .rd1_en_i(s1_rd_en_i),
    .rs1_1_i(s1_rs1_i), .rs1_1_en_i(s1_rs1_en_i),
    .rs2_1_i(s1_rs2_i), .rs2_1_en_i(s1_rs2_en_i),
    .pair_ok_o(pair_ok)
  );

  di_scoreboard #(.NUM_REGS(NUM_REGS), .MULTI_LAT(MULTI_LAT), .REG_AW(REG_AW)) u_sb (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .q0_rs1_i(s0_rs1_i), .q0_rs1_en_i(s0_rs1_en_i),
    .q0_rs2_i(s0_rs2_i), .q0_rs2_en_i(s0_rs2_en_i),
    .q0_rd_i(s0_rd_i),   .q0_rd_en_i(s0_rd_en_i),
    .q1_rs1_i(s1_rs1_i), .q1_rs1_en_i(s1_rs1_en_i),
    .q1_rs2_i(s1_rs2_i), .q1_rs2_en_i(s1_rs2_en_i),
    .q1_rd_i(s1_rd_i),   .q1_rd_en_i(s1_rd_en_i),
    .set0_i(set0), .set0_rd_i(s0_rd_i),
    .set1_i(set1), .set1_rd_i(s1_rd_i),
    .block0_o(block0), .block1_o(block1)
  );

  assign issue0_o = s0_valid_i && !block0;
  assign issue1_o = issue0_o && s1_valid_i && pair_ok && !block1;
  assign issue_cnt_o = issue1_o ? 2'd2 : (issue0_o ? 2'd1 : 2'd0);

  assign set0 = issue0_o && s0_rd_en_i && is_multi_cycle(cls0);
  assign set1 = issue1_o && s1_rd_en_i && is_multi_cycle(cls1);

  di_steer u_steer (
    .cls0_i(cls0), .cls1_i(cls1), .dual_i(issue1_o),
    .pipe0_o(pipe0), .pipe1_o(pipe1)
  );

  assign pipe0_o = pipe0;
  assign pipe1_o = pipe1;

  assert_in_order_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue1_o |-> issue0_o);

  assert_no_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s0_valid_i |-> (issue_cnt_o == 2'd0));

  assert_no_raw_pair_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue1_o |-> !(s0_rd_en_i && ((s1_rs1_en_i && s1_rs1_i == s0_rd_i) ||
                                  (s1_rs2_en_i && s1_rs2_i == s0_rd_i))));

  assert_rd_ports_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue1_o |-> ($countones({s0_rs1_en_i, s0_rs2_en_i, s1_rs1_en_i, s1_rs2_en_i})
                  <= RD_PORTS));

  assert_nop_solo_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue1_o |-> (s0_cls_i != 3'd7 && s1_cls_i != 3'd7));

  assert_pipes_distinct_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue1_o |-> (pipe0_o != pipe1_o));

  assert_complex_alu_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue0_o && (s0_cls_i == 3'd3 || s0_cls_i == 3'd4)) |-> (pipe0_o == 2'd1));

  assert_sb_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue0_o && s0_cls_i == 3'd3 && s0_rd_en_i) |=>
      !(issue0_o && s0_rs1_en_i && s0_rs1_i == $past(s0_rd_i)));

endmodule

// File: tb/dual_issue_stage_tb.sv
module dual_issue_stage_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] MOV = 3'd0, ALU = 3'd1, ALUI = 3'd2, MUL = 3'd3,
                         SHF = 3'd4, BR = 3'd5, LDST = 3'd6, NOP = 3'd7;

  typedef struct packed {
    logic [2:0] c0; logic [2:0] c1; logic [3:0] d0; logic [1:0] u0;
    logic [3:0] a1; logic [3:0] b1; logic [1:0] u1; logic [1:0] v;
    logic [1:0] n;  logic [1:0] p0; logic [1:0] p1;
  } vec_t;

  localparam int NV = 26;
  // u = {rs1_en, rs2_en}; v = {s1_valid, s0_valid}
  localparam vec_t VECS [NV] = '{
    '{MOV,  MOV,  4'd3, 2'b10, 4'd5, 4'd6, 2'b10, 2'b11, 2'd2, 2'd1, 2'd0},  // R5
    '{ALU,  ALU,  4'd3, 2'b11, 4'd5, 4'd6, 2'b11, 2'b11, 2'd1, 2'd1, 2'd0},  // R4 R5
    '{ALU,  ALUI, 4'd3, 2'b11, 4'd5, 4'd6, 2'b10, 2'b11, 2'd2, 2'd1, 2'd0},  // R5
    '{MUL,  BR,   4'd3, 2'b11, 4'd5, 4'd6, 2'b00, 2'b11, 2'd2, 2'd1, 2'd3},  // R5 R8
    '{MUL,  ALUI, 4'd3, 2'b11, 4'd5, 4'd6, 2'b10, 2'b11, 2'd1, 2'd1, 2'd0},  // R5
    '{SHF,  ALUI, 4'd3, 2'b11, 4'd5, 4'd6, 2'b10, 2'b11, 2'd2, 2'd1, 2'd0},  // R5
    '{ALUI, SHF,  4'd3, 2'b10, 4'd5, 4'd6, 2'b11, 2'b11, 2'd2, 2'd0, 2'd1},  // R8
    '{LDST, MOV,  4'd3, 2'b11, 4'd5, 4'd6, 2'b10, 2'b11, 2'd2, 2'd2, 2'd0},  // R5
    '{LDST, LDST, 4'd3, 2'b11, 4'd5, 4'd6, 2'b11, 2'b11, 2'd1, 2'd2, 2'd0},  // R5
    '{LDST, ALU,  4'd3, 2'b11, 4'd5, 4'd6, 2'b11, 2'b11, 2'd1, 2'd2, 2'd0},  // R5
    '{BR,   BR,   4'd3, 2'b00, 4'd5, 4'd6, 2'b00, 2'b11, 2'd1, 2'd3, 2'd0},  // R5
    '{BR,   MUL,  4'd3, 2'b00, 4'd5, 4'd6, 2'b11, 2'b11, 2'd2, 2'd3, 2'd1},  // R8
    '{NOP,  MOV,  4'd3, 2'b00, 4'd5, 4'd6, 2'b10, 2'b11, 2'd1, 2'd0, 2'd0},  // R6
    '{MOV,  NOP,  4'd3, 2'b10, 4'd5, 4'd6, 2'b00, 2'b11, 2'd1, 2'd1, 2'd0},  // R6
    '{MOV,  MUL,  4'd3, 2'b10, 4'd5, 4'd6, 2'b11, 2'b11, 2'd1, 2'd1, 2'd0},  // R5
    '{MOV,  LDST, 4'd3, 2'b10, 4'd5, 4'd6, 2'b11, 2'b11, 2'd1, 2'd1, 2'd0},  // R5
    '{MOV,  SHF,  4'd3, 2'b10, 4'd5, 4'd6, 2'b11, 2'b11, 2'd2, 2'd0, 2'd1},  // R8
    '{SHF,  MOV,  4'd3, 2'b11, 4'd5, 4'd6, 2'b10, 2'b11, 2'd1, 2'd1, 2'd0},  // R5
    '{ALUI, ALU,  4'd3, 2'b10, 4'd3, 4'd6, 2'b11, 2'b11, 2'd1, 2'd1, 2'd0},  // R3
    '{ALUI, ALU,  4'd3, 2'b10, 4'd5, 4'd3, 2'b11, 2'b11, 2'd1, 2'd1, 2'd0},  // R3
    '{ALUI, MOV,  4'd3, 2'b10, 4'd3, 4'd6, 2'b00, 2'b11, 2'd2, 2'd1, 2'd0},  // R3
    '{MOV,  MOV,  4'd3, 2'b10, 4'd5, 4'd6, 2'b10, 2'b01, 2'd1, 2'd1, 2'd0},  // R2
    '{MOV,  MOV,  4'd3, 2'b10, 4'd5, 4'd6, 2'b10, 2'b10, 2'd0, 2'd0, 2'd0},  // R2
    '{MOV,  MOV,  4'd4, 2'b10, 4'd5, 4'd6, 2'b10, 2'b11, 2'd1, 2'd1, 2'd0},  // R12
    '{LDST, ALUI, 4'd3, 2'b11, 4'd5, 4'd6, 2'b11, 2'b11, 2'd1, 2'd2, 2'd0},  // R4
    '{ALUI, ALUI, 4'd3, 2'b10, 4'd5, 4'd6, 2'b10, 2'b11, 2'd2, 2'd1, 2'd0}   // R5
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s0_v = 1'b0, s1_v = 1'b0;
  logic [2:0] s0_c = 3'd0, s1_c = 3'd0;
  logic [3:0] s0_rd = 4'd0, s0_a = 4'd0, s0_b = 4'd0;
  logic [3:0] s1_rd = 4'd0, s1_a = 4'd0, s1_b = 4'd0;
  logic       s0_rde = 1'b0, s0_ae = 1'b0, s0_be = 1'b0;
  logic       s1_rde = 1'b0, s1_ae = 1'b0, s1_be = 1'b0;
  logic       iss0, iss1;
  logic [1:0] p0, p1, cnt;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_issue_stage u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .s0_valid_i(s0_v), .s0_cls_i(s0_c), .s0_rd_i(s0_rd), .s0_rd_en_i(s0_rde),
    .s0_rs1_i(s0_a), .s0_rs1_en_i(s0_ae), .s0_rs2_i(s0_b), .s0_rs2_en_i(s0_be),
    .s1_valid_i(s1_v), .s1_cls_i(s1_c), .s1_rd_i(s1_rd), .s1_rd_en_i(s1_rde),
    .s1_rs1_i(s1_a), .s1_rs1_en_i(s1_ae), .s1_rs2_i(s1_b), .s1_rs2_en_i(s1_be),
    .issue0_o(iss0), .issue1_o(iss1), .pipe0_o(p0), .pipe1_o(p1), .issue_cnt_o(cnt)
  );

  task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic slot0(input logic v, input logic [2:0] c, input logic [3:0] rd,
                       input logic rde, input logic [3:0] a, input logic ae,
                       input logic [3:0] b, input logic be);
    s0_v = v; s0_c = c; s0_rd = rd; s0_rde = rde;
    s0_a = a; s0_ae = ae; s0_b = b; s0_be = be;
  endtask

  task automatic slot1(input logic v, input logic [2:0] c, input logic [3:0] rd,
                       input logic rde, input logic [3:0] a, input logic ae,
                       input logic [3:0] b, input logic be);
    s1_v = v; s1_c = c; s1_rd = rd; s1_rde = rde;
    s1_a = a; s1_ae = ae; s1_b = b; s1_be = be;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: fresh state, consumer of any register issues
    slot0(1'b1, MOV, 4'd8, 1'b1, 4'd3, 1'b1, 4'd0, 1'b0);
    slot1(1'b0, MOV, 4'd9, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0);
    #1 chk("R1 count after reset", cnt, 2'd1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      slot0(VECS[i].v[0], VECS[i].c0, VECS[i].d0, 1'b1, 4'd1, VECS[i].u0[1], 4'd2, VECS[i].u0[0]);
      slot1(VECS[i].v[1], VECS[i].c1, 4'd4, 1'b1, VECS[i].a1, VECS[i].u1[1], VECS[i].b1, VECS[i].u1[0]);
      #1;
      chk($sformatf("R7 vec%0d count", i), cnt, VECS[i].n);
      if (VECS[i].n != 2'd0) chk($sformatf("R8 vec%0d pipe0", i), p0, VECS[i].p0);
      if (VECS[i].n == 2'd2) chk($sformatf("R8 vec%0d pipe1", i), p1, VECS[i].p1);
      @(negedge clk);
      s0_v = 1'b0; s1_v = 1'b0;
      repeat (4) @(negedge clk);
    end

    // R9 R10: multiply rd7, then dependent mov + independent alui
    @(negedge clk);
    slot0(1'b1, MUL, 4'd7, 1'b1, 4'd1, 1'b1, 4'd2, 1'b1);
    slot1(1'b0, MOV, 4'd9, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0);
    #1 chk("R9 mul issues", cnt, 2'd1);
    @(negedge clk);
    slot0(1'b1, MOV, 4'd8, 1'b1, 4'd7, 1'b1, 4'd0, 1'b0);
    slot1(1'b1, ALUI, 4'd9, 1'b1, 4'd10, 1'b1, 4'd0, 1'b0);
    #1 chk("R10 held cycle 1", cnt, 2'd0);
    @(negedge clk); #1 chk("R9 held cycle 2", cnt, 2'd0);
    @(negedge clk); #1 chk("R9 released cycle 3", cnt, 2'd2);
    @(negedge clk); s0_v = 1'b0; s1_v = 1'b0;
    repeat (4) @(negedge clk);

    // R10: write-after-write on pending register held
    slot0(1'b1, LDST, 4'd7, 1'b1, 4'd1, 1'b1, 4'd0, 1'b0);
    #1 chk("R9 load issues", cnt, 2'd1);
    @(negedge clk);
    slot0(1'b1, ALUI, 4'd7, 1'b1, 4'd1, 1'b1, 4'd0, 1'b0);
    #1 chk("R10 waw held", cnt, 2'd0);
    @(negedge clk); s0_v = 1'b0;
    repeat (4) @(negedge clk);

    // R11: independent multiplies then loads, one per cycle
    for (int k = 0; k < 4; k++) begin
      slot0(1'b1, MUL, 4'(10 + k), 1'b1, 4'd1, 1'b1, 4'd2, 1'b1);
      #1 chk("R11 mul stream", cnt, 2'd1);
      @(negedge clk);
    end
    for (int k = 0; k < 4; k++) begin
      slot0(1'b1, LDST, 4'(k + 4), 1'b1, 4'd0, 1'b1, 4'd0, 1'b0);
      #1 chk("R11 load stream", cnt, 2'd1);
      @(negedge clk);
    end
    s0_v = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule